// File: doc/BRIEF.md
# DMA Channel Source Address Sequencer

This block is the read side and the stop logic of one DMA channel. Software loads a source address, a byte count and a control word through a small register write port. It can read any of these back, together with a status word, through a combinational read mux. Each accepted transfer request issues one read at the current source address. A read that succeeds moves the address forward by the transfer size (only in increment mode) and lowers the byte count by that size.

The channel stops through sticky status flags, not through a busy bit. There are four flags:
- a bad-configuration flag;
- a count-exhausted flag;
- a bus-error flag;
- a progress flag that shows a transfer has succeeded.

The first three block all further requests until software clears them by writing ones. The progress flag is cleared only by a synchronous channel reset. That channel reset also zeroes the byte count.

Top module: `dma_src_seq`

## Requirements
- R1: After the active-low hardware reset, the source address, byte count, control word and status word all read as zero.
- R2: While `rd_valid` is high, `rd_addr` equals the source address held before that clock edge. Register select 0 reads the source address, and a write to select 0 loads it.
- R3: The control word is written at select 2 and holds enable in bit 0, the address mode in bits 2:1 and the size code in bits 4:3. Size code 00, 01 and 10 mean 1, 2 and 4 bytes. Address mode 00 keeps the address unchanged after a read. Address mode 01 adds the transfer size after each successful read. A register write to select 0 takes priority over the advance.
- R4: The byte count is at select 1. Each successful read lowers it by the transfer size, and it stops at zero rather than wrapping. When a successful read leaves it at zero, the count-exhausted flag sets. A write to select 1 loads the count and takes priority over the decrement.
- R5: `rd_valid` equals `xfer_req` AND enable AND (byte count nonzero) AND (configuration legal) AND (no blocking flag set).
- R6: When `bus_err` is high in an accepted cycle, the bus-error flag sets. The address, the byte count and the progress flag stay unchanged.
- R7: A control write with address mode 1x or size code 11 sets the bad-configuration flag. While the held configuration is illegal, requests are refused.
- R8: The status word is at select 3, with bit 4 = bad-configuration, bit 3 = count-exhausted, bit 2 = reserved (reads 0), bit 1 = bus-error and bit 0 = progress. Writing 1 to bit 4, 3 or 1 clears that flag. Writing 0 has no effect. Status writes never change the progress bit.
- R9: The progress flag sets after every successful read. While `mod_rst` is high, the byte count and all four status flags clear at the next edge; the address and control word keep their values.
- R10: If a flag is set and cleared by software in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mod_rst | input | 1 | Synchronous channel reset: clears the count and the flags |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_sel` |
| xfer_req | input | 1 | Request for one read transfer |
| bus_err | input | 1 | Bus error reported for the read issued this cycle |
| rd_valid | output | 1 | A read is issued this cycle |
| rd_addr | output | 32 | Read address |

## Verification
The assertions assume that `bus_err` is a same-cycle response to the read issued in that cycle, and that it has no meaning in any other cycle. They also assume that a register write to the address or the count, in the same cycle as a read, replaces that read's update. The address and count assertions are therefore guarded by the absence of a register write. The stimulus drives all inputs at the falling edge and holds them for a whole cycle. It loads small counts so that exhaustion happens often, and it clears flags with random masks. The reference model in the bench follows the same write-wins and set-wins ordering stated in R3, R4 and R10.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    AM_HOLD = 2'b00,
    AM_INC  = 2'b01,
    AM_RSV2 = 2'b10,
    AM_RSV3 = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_STAT = 2'd3
  } rsel_e;

  typedef struct packed {
    logic [1:0] size;
    amode_e     amode;
    logic       en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // bytes moved per read for a size code; 0 for the illegal code
  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   step_bytes = 3'd1;
      2'b01:   step_bytes = 3'd2;
      2'b10:   step_bytes = 3'd4;
      default: step_bytes = 3'd0;
    endcase
  endfunction

  function automatic logic cfg_illegal(input ctl_t c);
    cfg_illegal = c.amode[1] | (c.size == 2'b11);
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  amode_e            amode,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] step_ext;

  assign step_ext = {{(ADDR_W-3){1'b0}}, step_bytes(size)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (adv && amode == AM_INC) begin
      addr <= addr + step_ext;
    end
  end

endmodule

// File: rtl/dma_byte_cnt.sv
module dma_byte_cnt
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic [1:0]       size,
  output logic [CNT_W-1:0] cnt,
  output logic             hits_zero
);

  logic [CNT_W-1:0] step_ext;

  assign step_ext  = {{(CNT_W-3){1'b0}}, step_bytes(size)};
  assign hits_zero = dec && (cnt <= step_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec) begin
      cnt <= hits_zero ? '0 : cnt - step_ext;
    end
  end

endmodule

// File: rtl/dma_stat_flags.sv
module dma_stat_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_all,
  input  logic       set_inv,
  input  logic       set_asc,
  input  logic       set_te,
  input  logic       set_tc,
  input  logic       w1c_we,
  input  logic [4:0] w1c_bits,
  output logic       flg_inv,
  output logic       flg_asc,
  output logic       flg_te,
  output logic       flg_tc
);

  logic clr_inv, clr_asc, clr_te;

  assign clr_inv = w1c_we && w1c_bits[4];
  assign clr_asc = w1c_we && w1c_bits[3];
  assign clr_te  = w1c_we && w1c_bits[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_inv <= 1'b0;
      flg_asc <= 1'b0;
      flg_te  <= 1'b0;
      flg_tc  <= 1'b0;
    end else if (clr_all) begin
      flg_inv <= 1'b0;
      flg_asc <= 1'b0;
      flg_te  <= 1'b0;
      flg_tc  <= 1'b0;
    end else begin
      flg_inv <= set_inv | (flg_inv & ~clr_inv);
      flg_asc <= set_asc | (flg_asc & ~clr_asc);
      flg_te  <= set_te  | (flg_te  & ~clr_te);
      flg_tc  <= set_tc  | flg_tc;
    end
  end

endmodule

// File: rtl/dma_src_seq.sv
module dma_src_seq
  import dma_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_req,
  input  logic              bus_err,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_addr
);

  localparam int PAD_CNT = DATA_W - CNT_W;
  localparam int PAD_CTL = DATA_W - CTL_W;

  ctl_t             ctl_q;
  logic [DATA_W-1:0] src_addr;
  logic [CNT_W-1:0]  cnt;
  logic              flg_inv, flg_asc, flg_te, flg_tc;

  // named internal events
  logic blocked, cfg_bad, rd_ok, rd_fail, cnt_zero_evt;
  logic wr_src, wr_cnt, wr_ctl, wr_stat, ctl_write_bad;

  assign wr_src  = reg_we && reg_sel == SEL_SRC;
  assign wr_cnt  = reg_we && reg_sel == SEL_CNT;
  assign wr_ctl  = reg_we && reg_sel == SEL_CTL;
  assign wr_stat = reg_we && reg_sel == SEL_STAT;

  assign ctl_write_bad = wr_ctl && cfg_illegal(ctl_t'(reg_wdata[CTL_W-1:0]));
  assign blocked       = flg_inv | flg_asc | flg_te;
  assign cfg_bad       = cfg_illegal(ctl_q);

  assign rd_valid = xfer_req && ctl_q.en && !cfg_bad && (cnt != '0) && !blocked;
  assign rd_addr  = src_addr;
  assign rd_ok    = rd_valid && !bus_err;
  assign rd_fail  = rd_valid && bus_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_ctl) begin
      ctl_q <= ctl_t'(reg_wdata[CTL_W-1:0]);
    end
  end

  dma_addr_step #(.ADDR_W(DATA_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_src),
    .load_val(reg_wdata),
    .adv     (rd_ok),
    .amode   (ctl_q.amode),
    .size    (ctl_q.size),
    .addr    (src_addr)
  );

  dma_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mod_rst),
    .load     (wr_cnt),
    .load_val (reg_wdata[CNT_W-1:0]),
    .dec      (rd_ok),
    .size     (ctl_q.size),
    .cnt      (cnt),
    .hits_zero(cnt_zero_evt)
  );

  dma_stat_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (mod_rst),
    .set_inv (ctl_write_bad),
    .set_asc (cnt_zero_evt),
    .set_te  (rd_fail),
    .set_tc  (rd_ok),
    .w1c_we  (wr_stat),
    .w1c_bits(reg_wdata[4:0]),
    .flg_inv (flg_inv),
    .flg_asc (flg_asc),
    .flg_te  (flg_te),
    .flg_tc  (flg_tc)
  );

  always_comb begin
    case (reg_sel)
      SEL_SRC: reg_rdata = src_addr;
      SEL_CNT: reg_rdata = {{PAD_CNT{1'b0}}, cnt};
      SEL_CTL: reg_rdata = {{PAD_CTL{1'b0}}, ctl_q};
      default: reg_rdata = {{(DATA_W-5){1'b0}}, flg_inv, flg_asc, 1'b0, flg_te, flg_tc};
    endcase
  end

endmodule

// File: rtl/dma_src_seq_chk.sv
module dma_src_seq_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mod_rst,
  input logic              reg_we,
  input logic              rd_valid,
  input logic              bus_err,
  input logic              en,
  input logic              cfg_bad,
  input logic              blocked,
  input logic [1:0]        amode,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] src_addr,
  input logic              flg_inv,
  input logic              flg_te,
  input logic              flg_tc,
  input logic              ctl_write_bad
);

  // R5
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (en && !cfg_bad && !blocked && cnt != '0));

  // R6
  err_sets_te_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && bus_err && !mod_rst) |=> flg_te);

  // R6
  err_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && bus_err && !reg_we) |=> $stable(src_addr));

  // R3
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && amode == 2'b00 && !reg_we) |=> $stable(src_addr));

  // R4
  cnt_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !bus_err && !mod_rst && !reg_we) |=> (cnt < $past(cnt)));

  // R7
  inv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_inv) |-> $past(ctl_write_bad));

  // R9
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_tc && !mod_rst) |=> flg_tc);

endmodule

bind dma_src_seq dma_src_seq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mod_rst      (mod_rst),
  .reg_we       (reg_we),
  .rd_valid     (rd_valid),
  .bus_err      (bus_err),
  .en           (ctl_q.en),
  .cfg_bad      (cfg_bad),
  .blocked      (blocked),
  .amode        (ctl_q.amode),
  .cnt          (cnt),
  .src_addr     (src_addr),
  .flg_inv      (flg_inv),
  .flg_te       (flg_te),
  .flg_tc       (flg_tc),
  .ctl_write_bad(ctl_write_bad)
);

// File: tb/dma_src_seq_bench.sv
module dma_src_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_rst = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_req = 1'b0;
  logic        bus_err = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_addr = '0;
  logic [15:0] m_cnt = '0;
  logic [4:0]  m_ctl = '0;
  bit m_inv = 0, m_asc = 0, m_te = 0, m_tc = 0;

  always #4 clk = ~clk;

  dma_src_seq u_dma_src_seq (
    .clk(clk), .rst_n(rst_n), .mod_rst(mod_rst), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_req(xfer_req), .bus_err(bus_err), .rd_valid(rd_valid), .rd_addr(rd_addr)
  );

  function automatic int unsigned size_of(logic [1:0] code);
    if (code == 2'd0) return 1;
    if (code == 2'd1) return 2;
    if (code == 2'd2) return 4;
    return 0;
  endfunction

  function automatic bit bad_cfg(logic [4:0] c);
    return c[2] || (c[4:3] == 2'b11);
  endfunction

  function automatic bit will_accept(bit req);
    return req && m_ctl[0] && !bad_cfg(m_ctl) && (m_cnt != 0) && !(m_inv || m_asc || m_te);
  endfunction

  function automatic logic [31:0] exp_read(logic [1:0] sel);
    case (sel)
      2'd0: return m_addr;
      2'd1: return {16'd0, m_cnt};
      2'd2: return {27'd0, m_ctl};
      default: return {27'd0, m_inv, m_asc, 1'b0, m_te, m_tc};
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step(bit we, logic [1:0] sel, logic [31:0] wd, bit req, bit err, bit mr);
    bit acc, ok, clr3;
    int unsigned sz;
    acc  = will_accept(req);
    ok   = acc && !err;
    sz   = size_of(m_ctl[4:3]);
    clr3 = we && sel == 2'd3;
    if (we && sel == 2'd0) m_addr = wd;
    else if (ok && m_ctl[2:1] == 2'b01) m_addr = m_addr + sz;
    if (mr) begin
      m_inv = 0; m_asc = 0; m_te = 0; m_tc = 0;
    end else begin
      m_inv = (m_inv && !(clr3 && wd[4])) || (we && sel == 2'd2 && bad_cfg(wd[4:0]));
      m_asc = (m_asc && !(clr3 && wd[3])) || (ok && m_cnt <= sz);
      m_te  = (m_te  && !(clr3 && wd[1])) || (acc && err);
      m_tc  = m_tc || ok;
    end
    if (mr) m_cnt = 0;
    else if (we && sel == 2'd1) m_cnt = wd[15:0];
    else if (ok) m_cnt = (m_cnt <= sz) ? 16'd0 : m_cnt - 16'(sz);
    if (we && sel == 2'd2) m_ctl = wd[4:0];
  endtask

  // one cycle: drive at falling edge, compare, then advance the model
  task automatic cyc(bit we, logic [1:0] sel, logic [31:0] wd, bit req, bit err, bit mr);
    bit exp_v;
    @(negedge clk);
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    xfer_req = req; bus_err = err; mod_rst = mr;
    #1;
    exp_v = will_accept(req);
    check("R5 rd_valid", {31'd0, rd_valid}, {31'd0, exp_v});
    if (exp_v) check("R2 rd_addr", rd_addr, m_addr);
    case (sel)
      2'd0: check("R3 address read", reg_rdata, exp_read(sel));
      2'd1: check("R4 count read", reg_rdata, exp_read(sel));
      2'd2: check("R7 control read", reg_rdata, exp_read(sel));
      default: check("R8 status read", reg_rdata, exp_read(sel));
    endcase
    @(posedge clk);
    model_step(we, sel, wd, req, err, mr);
  endtask

  task automatic peek(logic [1:0] sel, string req, logic [31:0] exp);
    @(negedge clk);
    reg_we = 0; reg_sel = sel; xfer_req = 0; bus_err = 0; mod_rst = 0;
    #1;
    check(req, reg_rdata, exp);
    @(posedge clk);
    model_step(0, sel, '0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    peek(2'd0, "R1 address after reset", 32'h0);
    peek(2'd1, "R1 count after reset", 32'h0);
    peek(2'd2, "R1 control after reset", 32'h0);
    peek(2'd3, "R1 status after reset", 32'h0);

    // increment mode, 2-byte steps, count 6
    cyc(1, 2'd0, 32'h100, 0, 0, 0);
    cyc(1, 2'd1, 32'd6, 0, 0, 0);
    cyc(1, 2'd2, 32'h0B, 0, 0, 0);
    cyc(0, 2'd3, 0, 1, 0, 0);
    cyc(0, 2'd3, 0, 1, 0, 0);
    cyc(0, 2'd3, 0, 1, 0, 0);
    peek(2'd0, "R3 address after three 2-byte reads", 32'h106);
    peek(2'd3, "R4 exhausted and progress flags", 32'h09);
    cyc(0, 2'd1, 0, 1, 0, 0); // R5 refused while exhausted

    // R8 write-one-to-clear
    cyc(1, 2'd3, 32'h0, 0, 0, 0);
    peek(2'd3, "R8 zero write ignored", 32'h09);
    cyc(1, 2'd3, 32'h08, 0, 0, 0);
    peek(2'd3, "R8 exhausted flag cleared", 32'h01);
    cyc(1, 2'd3, 32'h1F, 0, 0, 0);
    peek(2'd3, "R8 progress flag survives status write", 32'h01);

    // R6 bus error
    cyc(1, 2'd1, 32'd8, 0, 0, 0);
    cyc(0, 2'd0, 0, 1, 1, 0);
    peek(2'd3, "R6 error flag set", 32'h03);
    peek(2'd0, "R6 address unchanged", 32'h106);
    peek(2'd1, "R6 count unchanged", 32'd8);
    cyc(1, 2'd3, 32'h02, 0, 0, 0);

    // R7 illegal configuration
    cyc(1, 2'd2, 32'h05, 0, 0, 0);
    peek(2'd3, "R7 bad-config flag set", 32'h11);
    cyc(1, 2'd3, 32'h10, 0, 0, 0);
    cyc(0, 2'd3, 0, 1, 0, 0); // refused: config still illegal
    peek(2'd1, "R7 count untouched by refused request", 32'd8);
    cyc(1, 2'd2, 32'h0B, 0, 0, 0);

    // R10 set and clear in the same cycle
    cyc(1, 2'd3, 32'h02, 1, 1, 0);
    peek(2'd3, "R10 set wins over clear", 32'h03);

    // R9 channel reset
    cyc(0, 2'd3, 0, 0, 0, 1);
    peek(2'd3, "R9 flags cleared by channel reset", 32'h0);
    peek(2'd1, "R9 count cleared by channel reset", 32'h0);
    peek(2'd0, "R9 address kept by channel reset", 32'h106);

    // R3 hold mode with 4-byte steps
    cyc(1, 2'd2, 32'h11, 0, 0, 0);
    cyc(1, 2'd1, 32'd12, 0, 0, 0);
    cyc(0, 2'd0, 0, 1, 0, 0);
    cyc(0, 2'd0, 0, 1, 0, 0);
    peek(2'd0, "R3 hold mode keeps address", 32'h106);
    peek(2'd1, "R4 count minus eight", 32'd4);

    // R4 saturation: count 3 with 4-byte step
    cyc(1, 2'd1, 32'd3, 0, 0, 0);
    cyc(0, 2'd0, 0, 1, 0, 0);
    peek(2'd1, "R4 count stops at zero", 32'd0);
    peek(2'd3, "R4 exhausted after short count", 32'h09);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      bit we, req, err, mr;
      logic [1:0] sel;
      logic [31:0] wd;
      r   = $urandom_range(0, 99);
      we  = (r < 18);
      sel = 2'($urandom_range(0, 3));
      req = ($urandom_range(0, 9) < 8);
      err = ($urandom_range(0, 99) < 5);
      mr  = ($urandom_range(0, 199) < 3);
      case (sel)
        2'd0: wd = $urandom;
        2'd1: wd = 32'($urandom_range(0, 40));
        2'd2: wd = ($urandom_range(0, 9) < 8) ?
                   {27'd0, 2'($urandom_range(0, 2)), 2'($urandom_range(0, 1)), 1'b1} :
                   32'($urandom_range(0, 31));
        default: wd = 32'($urandom_range(0, 31));
      endcase
      cyc(we, sel, wd, req, err, mr);
    end

    finish_run();
  end

endmodule